// File: doc/BRIEF.md
# Redundant Thread Comparison Buffer

This block checks results produced by two redundant copies of one thread. The leading copy runs ahead and writes each result word into a buffer. The trailing copy produces the same words later. As each trailing word arrives, the block compares it with the oldest word still held for that thread pair and reports whether the two are equal.

The storage is split into independent sets, one for each redundant thread pair. Each set is a small first-in-first-out queue. Both copies give their pair index with every request, so each request goes straight to its own set. When a set is full, the block raises that pair's suspend output. This holds the leading copy until the trailing copy has drained some entries. A per-pair flush input empties one set, for use when the surrounding logic abandons that pair's pending results.

The comparison outcome is registered. It appears one clock after the trailing request, together with the pair index it belongs to.

Top module: `redcmp_buffer`

## Requirements
- R1: After reset, every set is empty, all `suspend` bits are 0 and `res_valid` is 0.
- R2: Words pushed by the leading copy for one pair are compared in the order they were pushed. A trailing word equal to the oldest held word gives `res_valid`=1 and `res_match`=1 one cycle after the request, and that entry is removed.
- R3: A trailing word that differs from the oldest held word gives a one-cycle pulse with `res_valid`=1 and `res_mismatch`=1, and `res_pair` equal to the requesting pair. The entry is still removed. At most one of `res_match`, `res_mismatch` and `res_underflow` is 1 in any cycle.
- R4: `suspend[i]` is 1 exactly while set i holds DEPTH entries (default 4).
- R5: A leading push to a full set is dropped unless the same set is popped in the same cycle.
- R6: A trailing request to an empty set gives `res_valid`=1 and `res_underflow`=1 one cycle later, and removes nothing.
- R7: A leading push and a trailing pop on the same set in the same cycle are both accepted, and the occupancy does not change. A full set stays full and keeps its suspend bit.
- R8: `flush[i]` empties set i by the next cycle and clears `suspend[i]`. In the flush cycle, a push to set i is dropped and a trailing request to set i reports underflow.
- R9: Each set is independent. Activity on one pair never changes the contents or the suspend bit of another pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lead_valid | input | 1 | Leading copy pushes a result word this cycle |
| lead_pair | input | PAIR_W (2) | Pair index of the push |
| lead_data | input | WIDTH (32) | Result word pushed |
| trail_valid | input | 1 | Trailing copy requests a compare this cycle |
| trail_pair | input | PAIR_W (2) | Pair index of the compare |
| trail_data | input | WIDTH (32) | Trailing result word to compare |
| flush | input | NPAIRS (4) | Per-pair set flush |
| suspend | output | NPAIRS (4) | Per-pair full indication to the leading copy |
| res_valid | output | 1 | A compare outcome is presented |
| res_match | output | 1 | Words were equal |
| res_mismatch | output | 1 | Words differed |
| res_underflow | output | 1 | Compare hit an empty set |
| res_pair | output | PAIR_W (2) | Pair index of the outcome |

## Verification
The assertions check, on every cycle, that the three outcome flags are mutually exclusive and follow a request one cycle later with its pair index. They also check that a suspend bit only rises after a push and only falls after a pop or a flush, that a flush always clears it, and that a compare on a full set never reports underflow. Only the bench scenarios can show the FIFO order, the value of each comparison, that a push to a full set is dropped, and the exact occupancy after a same-cycle push and pop. Long random runs against a queue model in the bench exercise the independence of the sets.

// File: rtl/redcmp_pkg.sv
package redcmp_pkg;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

   function automatic int idx_bits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/redcmp_set.sv
module redcmp_set
   import redcmp_pkg::*;
#(
   parameter int WIDTH = 32,
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_req,
   input  logic             pop_req,
   input  logic             flush,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] head,
   output logic             full,
   output logic             empty
);
   localparam int PTR_W = idx_bits(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CNT_W-1:0] occ;
   logic             push_ok, pop_ok;

   assign full    = (occ == CNT_W'(DEPTH));
   assign empty   = (occ == '0);
   assign pop_ok  = pop_req && !empty && !flush;
   assign push_ok = push_req && !flush && (!full || pop_ok);
   assign head    = mem[rd_ptr];

   generate
      if (DEPTH == (1 << PTR_W)) begin : g_wrap_nat
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         occ    <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         occ    <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_nxt;
         if (pop_ok)  rd_ptr <= rd_nxt;
         case ({push_ok, pop_ok})
            2'b10:   occ <= occ + 1'b1;
            2'b01:   occ <= occ - 1'b1;
            default: occ <= occ;
         endcase
      end
   end

endmodule

// File: rtl/redcmp_result.sv
module redcmp_result #(
   parameter int WIDTH  = 32,
   parameter int PAIR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmp_req,
   input  logic [PAIR_W-1:0] cmp_pair,
   input  logic [WIDTH-1:0]  cmp_data,
   input  logic [WIDTH-1:0]  head_data,
   input  logic              head_empty,
   output logic              res_valid,
   output logic              res_match,
   output logic              res_mismatch,
   output logic              res_underflow,
   output logic [PAIR_W-1:0] res_pair
);
   logic equal;
   assign equal = (cmp_data == head_data);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid     <= 1'b0;
         res_match     <= 1'b0;
         res_mismatch  <= 1'b0;
         res_underflow <= 1'b0;
         res_pair      <= '0;
      end else begin
         res_valid     <= cmp_req;
         res_underflow <= cmp_req && head_empty;
         res_match     <= cmp_req && !head_empty && equal;
         res_mismatch  <= cmp_req && !head_empty && !equal;
         res_pair      <= cmp_req ? cmp_pair : '0;
      end
   end

endmodule

// File: rtl/redcmp_buffer.sv
module redcmp_buffer
   import redcmp_pkg::*;
#(
   parameter int WIDTH  = 32,
   parameter int DEPTH  = 4,
   parameter int NPAIRS = 4,
   parameter int PAIR_W = idx_bits(NPAIRS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lead_valid,
   input  logic [PAIR_W-1:0] lead_pair,
   input  logic [WIDTH-1:0]  lead_data,
   input  logic              trail_valid,
   input  logic [PAIR_W-1:0] trail_pair,
   input  logic [WIDTH-1:0]  trail_data,
   input  logic [NPAIRS-1:0] flush,
   output logic [NPAIRS-1:0] suspend,
   output logic              res_valid,
   output logic              res_match,
   output logic              res_mismatch,
   output logic              res_underflow,
   output logic [PAIR_W-1:0] res_pair
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("redcmp_buffer: WIDTH must be at least 1");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("redcmp_buffer: DEPTH must be at least 2");
      end
      if (NPAIRS < 2 || !is_pow2(NPAIRS)) begin : g_bad_pairs
         $error("redcmp_buffer: NPAIRS must be a power of two, at least 2");
      end
      if (PAIR_W != idx_bits(NPAIRS)) begin : g_bad_pw
         $error("redcmp_buffer: PAIR_W must match NPAIRS");
      end
   endgenerate

   logic [WIDTH-1:0]  heads [NPAIRS];
   logic [NPAIRS-1:0] empties;
   logic [NPAIRS-1:0] fulls;
   logic [NPAIRS-1:0] push_sel, pop_sel;

   generate
      for (genvar i = 0; i < NPAIRS; i++) begin : g_set
         assign push_sel[i] = lead_valid  && (lead_pair  == PAIR_W'(i));
         assign pop_sel[i]  = trail_valid && (trail_pair == PAIR_W'(i));

         redcmp_set #(
            .WIDTH (WIDTH),
            .DEPTH (DEPTH)
         ) u_set (
            .clk      (clk),
            .rst_n    (rst_n),
            .push_req (push_sel[i]),
            .pop_req  (pop_sel[i]),
            .flush    (flush[i]),
            .wdata    (lead_data),
            .head     (heads[i]),
            .full     (fulls[i]),
            .empty    (empties[i])
         );
      end
   endgenerate

   assign suspend = fulls;

   logic sel_empty;
   assign sel_empty = empties[trail_pair] || flush[trail_pair];

   redcmp_result #(
      .WIDTH  (WIDTH),
      .PAIR_W (PAIR_W)
   ) u_result (
      .clk           (clk),
      .rst_n         (rst_n),
      .cmp_req       (trail_valid),
      .cmp_pair      (trail_pair),
      .cmp_data      (trail_data),
      .head_data     (heads[trail_pair]),
      .head_empty    (sel_empty),
      .res_valid     (res_valid),
      .res_match     (res_match),
      .res_mismatch  (res_mismatch),
      .res_underflow (res_underflow),
      .res_pair      (res_pair)
   );

endmodule

// File: rtl/redcmp_buffer_chk.sv
module redcmp_buffer_chk #(
   parameter int WIDTH  = 32,
   parameter int DEPTH  = 4,
   parameter int NPAIRS = 4,
   parameter int PAIR_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lead_valid,
   input logic [PAIR_W-1:0] lead_pair,
   input logic [WIDTH-1:0]  lead_data,
   input logic              trail_valid,
   input logic [PAIR_W-1:0] trail_pair,
   input logic [WIDTH-1:0]  trail_data,
   input logic [NPAIRS-1:0] flush,
   input logic [NPAIRS-1:0] suspend,
   input logic              res_valid,
   input logic              res_match,
   input logic              res_mismatch,
   input logic              res_underflow,
   input logic [PAIR_W-1:0] res_pair
);
   // R3
   outcome_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({res_match, res_mismatch, res_underflow}));

   // R3
   outcome_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trail_valid |=> res_valid && (res_pair == $past(trail_pair))
                      && (res_match || res_mismatch || res_underflow));

   // R1
   no_spurious_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !trail_valid |=> !res_valid && !res_match && !res_mismatch && !res_underflow);

   // R6
   full_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trail_valid && suspend[trail_pair] && !flush[trail_pair] |=> !res_underflow);

   generate
      for (genvar i = 0; i < NPAIRS; i++) begin : g_pair_chk
         // R8
         flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            flush[i] |=> !suspend[i]);

         // R4
         suspend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            suspend[i] && !flush[i] && !(trail_valid && trail_pair == PAIR_W'(i))
            |=> suspend[i]);

         // R4
         suspend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(suspend[i]) |-> $past(lead_valid && lead_pair == PAIR_W'(i)));
      end
   endgenerate

endmodule

bind redcmp_buffer redcmp_buffer_chk #(
   .WIDTH  (WIDTH),
   .DEPTH  (DEPTH),
   .NPAIRS (NPAIRS),
   .PAIR_W (PAIR_W)
) u_chk (.*);

// File: tb/redcmp_buffer_test.sv
`timescale 1ns/1ps
module redcmp_buffer_test;
   localparam int NP = 4;
   localparam int D  = 4;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        lead_valid, trail_valid;
   logic [1:0]  lead_pair, trail_pair, res_pair;
   logic [31:0] lead_data, trail_data;
   logic [3:0]  flush, suspend;
   logic        res_valid, res_match, res_mismatch, res_underflow;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   logic [31:0] mq [NP][D];
   int          mcnt [NP];

   always #2.5 clk = ~clk;

   redcmp_buffer uut (
      .clk(clk), .rst_n(rst_n),
      .lead_valid(lead_valid), .lead_pair(lead_pair), .lead_data(lead_data),
      .trail_valid(trail_valid), .trail_pair(trail_pair), .trail_data(trail_data),
      .flush(flush), .suspend(suspend),
      .res_valid(res_valid), .res_match(res_match), .res_mismatch(res_mismatch),
      .res_underflow(res_underflow), .res_pair(res_pair)
   );

   task automatic check(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic logic [3:0] exp_suspend();
      logic [3:0] s;
      for (int i = 0; i < NP; i++) s[i] = (mcnt[i] == D);
      return s;
   endfunction

   task automatic step(string tag, bit lv, int lp, logic [31:0] ld,
                       bit tv, int tp, logic [31:0] td, logic [3:0] fl);
      bit e_u, e_mm, e_m;
      lead_valid = lv; lead_pair = 2'(lp); lead_data = ld;
      trail_valid = tv; trail_pair = 2'(tp); trail_data = td;
      flush = fl;
      e_u  = tv && (mcnt[tp] == 0 || fl[tp]);
      e_mm = tv && !e_u && (td != mq[tp][0]);
      e_m  = tv && !e_u && !e_mm;
      for (int i = 0; i < NP; i++) begin
         bit pop, push;
         pop  = tv && tp == i && mcnt[i] > 0 && !fl[i];
         push = lv && lp == i && !fl[i] && (mcnt[i] < D || pop);
         if (fl[i]) mcnt[i] = 0;
         else begin
            if (pop) begin
               for (int k = 0; k < D - 1; k++) mq[i][k] = mq[i][k+1];
               mcnt[i]--;
            end
            if (push) begin
               mq[i][mcnt[i]] = ld;
               mcnt[i]++;
            end
         end
      end
      @(posedge clk);
      @(negedge clk);
      check(tag, "res_valid", int'(res_valid), int'(tv));
      check(tag, "res_match", int'(res_match), int'(e_m));
      check(tag, "res_mismatch", int'(res_mismatch), int'(e_mm));
      check(tag, "res_underflow", int'(res_underflow), int'(e_u));
      if (tv) check(tag, "res_pair", int'(res_pair), tp);
      check(tag, "suspend", int'(suspend), int'(exp_suspend()));
   endtask

   task automatic idle(string tag);
      step(tag, 0, 0, 0, 0, 0, 0, 4'b0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h0000_5eed));
      for (int i = 0; i < NP; i++) mcnt[i] = 0;
      rst_n = 0; lead_valid = 0; trail_valid = 0; flush = 0;
      lead_pair = 0; trail_pair = 0; lead_data = 0; trail_data = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      @(posedge clk);
      @(negedge clk);
      // R1 reset state
      check("R1", "suspend", int'(suspend), 0);
      check("R1", "res_valid", int'(res_valid), 0);
      idle("R1");

      // R2 in-order compare on pair 1
      step("R2", 1, 1, 32'h100, 0, 0, 0, 4'b0);
      step("R2", 1, 1, 32'h101, 0, 0, 0, 4'b0);
      step("R2", 1, 1, 32'h102, 0, 0, 0, 4'b0);
      step("R2", 0, 0, 0, 1, 1, 32'h100, 4'b0);
      step("R2", 0, 0, 0, 1, 1, 32'h101, 4'b0);
      step("R2", 0, 0, 0, 1, 1, 32'h102, 4'b0);

      // R3 mismatch pulse, entry still removed
      step("R3", 1, 2, 32'hAAAA, 0, 0, 0, 4'b0);
      step("R3", 0, 0, 0, 1, 2, 32'hBBBB, 4'b0);
      idle("R3");
      step("R3", 0, 0, 0, 1, 2, 32'hAAAA, 4'b0);

      // R4 fill pair 0, R9 others unaffected, R5 push to full dropped
      for (int k = 0; k < D; k++) step("R4", 1, 0, 32'h10 + k, 0, 0, 0, 4'b0);
      step("R5", 1, 0, 32'h14, 0, 0, 0, 4'b0);
      step("R9", 1, 1, 32'h55, 0, 0, 0, 4'b0);
      for (int k = 0; k < D; k++) step("R5", 0, 0, 0, 1, 0, 32'h10 + k, 4'b0);
      step("R5", 0, 0, 0, 1, 0, 32'h14, 4'b0);
      step("R9", 0, 0, 0, 1, 1, 32'h55, 4'b0);

      // R7 push and pop same full set
      for (int k = 0; k < D; k++) step("R7", 1, 3, 32'h20 + k, 0, 0, 0, 4'b0);
      step("R7", 1, 3, 32'h24, 1, 3, 32'h20, 4'b0);
      for (int k = 1; k <= D; k++) step("R7", 0, 0, 0, 1, 3, 32'h20 + k, 4'b0);

      // R6 underflow on empty set, nothing removed
      step("R6", 0, 0, 0, 1, 2, 32'h77, 4'b0);
      step("R6", 1, 2, 32'h78, 0, 0, 0, 4'b0);
      step("R6", 0, 0, 0, 1, 2, 32'h78, 4'b0);

      // R8 flush with same-cycle push and compare
      for (int k = 0; k < D; k++) step("R8", 1, 1, 32'h30 + k, 0, 0, 0, 4'b0);
      step("R8", 1, 1, 32'h99, 1, 1, 32'h30, 4'b0010);
      step("R8", 0, 0, 0, 1, 1, 32'h99, 4'b0);

      // R9 random traffic across pairs
      for (int n = 0; n < 4000; n++) begin
         int tp;
         logic [31:0] td;
         tp = int'($urandom % NP);
         td = (($urandom % 4) != 0 && mcnt[tp] > 0) ? mq[tp][0] : $urandom % 16;
         step("R9", ($urandom % 3) != 0, int'($urandom % NP), $urandom % 16,
              ($urandom % 2) != 0, tp, td,
              (($urandom % 40) == 0) ? 4'($urandom) : 4'b0);
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule